// File: doc/BRIEF.md
# Reloadable 12-bit Interrupting Timer

This block is a down-counting interval timer driven by a small word-addressed register port. Software writes a 12-bit reload value and a prescaler divisor, then sets a run bit and an interrupt-enable bit in a control word. While running, a prescaler divides the input clock by (timebase + 1). Each prescaled tick moves the counter one step down. A tick that finds the counter already at zero is the terminal count: the counter takes the reload value again, an overflow flag is set, and an interrupt becomes pending if interrupts are enabled.

Software reads the live count, the overflow flag and the pending-interrupt flag through the same port. Reading the status word clears the overflow flag. To acknowledge an interrupt, software writes a control word with the interrupt-enable bit clear and then writes the previous control word back. Clearing the run bit freezes both the prescaler and the counter, so the acknowledge sequence resumes counting from where it stopped.

Register word indices: 0 control (bit 0 run, bit 1 interrupt enable), 1 reload, 2 timebase, 3 current count (read only), 4 status (bit 0 overflow, read only), 5 interrupt status (bit 0 pending, read only).

Top module: `rld_timer`

## Requirements
- R1: After reset every register index (0 to 7) reads as zero and `irq` is low.
- R2: A write to reload (index 1) or timebase (index 2) whose data has any bit at position 12 or above set is ignored. An accepted reload write loads the counter with the written value at once and restarts the prescaler from zero.
- R3: While control bit 0 is set, the prescaler produces one tick every timebase+1 clock cycles, and each tick decrements a nonzero counter by one.
- R4: A tick that finds the counter at zero reloads it from the reload register and sets the overflow flag (status bit 0). The terminal count therefore repeats every (reload+1)*(timebase+1) running cycles.
- R5: A read of status (index 4) returns the overflow flag and clears it. A terminal count in the same cycle as the read leaves the flag set.
- R6: While control bit 0 is clear, the prescaler and the counter hold their values.
- R7: A terminal count while control bit 1 is set makes an interrupt pending. The pending flag drives `irq` and reads as bit 0 of index 5.
- R8: A terminal count while control bit 1 is clear leaves the pending flag unchanged but still sets the overflow flag.
- R9: A control write with bit 1 clear clears the pending flag, even against a terminal count in the same cycle. Writing the old control word back resumes counting from the held count.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_rd`. Index 3 returns the count as it was before that edge. Indices 0 to 2 read back the stored values, and indices 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Pending timer interrupt |

## Verification
The counting path is tried with these settings:
- a zero reload, where every tick is a terminal count;
- the full 0xFFF reload, so the counter never wraps within the window;
- divided and undivided timebases;
- run windows that end one tick before and exactly at the terminal count, which separates the decrement path from the wrap path.

Directed cases cover the remaining behaviour:
- out-of-range writes are rejected;
- a running timer with interrupts disabled sets the overflow flag but no interrupt;
- the zero-and-restore acknowledge, with a check that the count held and then resumed;
- a status read that lands on a terminal count, which shows whether the set or the clear of the overflow flag wins.

// File: rtl/rld_timer_pkg.sv
package rld_timer_pkg;

  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_RELOAD = 3'd1,
    REG_TBASE  = 3'd2,
    REG_VALUE  = 3'd3,
    REG_STAT   = 3'd4,
    REG_IRQST  = 3'd5
  } reg_idx_e;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_IRQ_BIT = 1;

  typedef struct packed {
    logic irq_en;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/rld_rst_sync.sv
module rld_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/rld_regs.sv
module rld_regs
  import rld_timer_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 12,
  parameter int unsigned TB_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              ovf,
  input  logic              pend,
  output logic [DW-1:0]     bus_rdata,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic [TB_W-1:0]   tbase,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              ack,
  output logic              stat_rd
);

  logic              wr_ctrl, wr_rl, wr_tb;
  logic              rl_fits, tb_fits;
  ctrl_t             ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  reload_q, reload_d;
  logic [TB_W-1:0]   tbase_q, tbase_d;
  logic [DW-1:0]     rdata_q, rdata_d;

  // address decode and range check
  assign rl_fits = ((bus_wdata >> CNT_W) == '0);
  assign tb_fits = ((bus_wdata >> TB_W) == '0);
  assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
  assign wr_rl   = bus_wr && (bus_addr == REG_RELOAD) && rl_fits;
  assign wr_tb   = bus_wr && (bus_addr == REG_TBASE) && tb_fits;

  // next state
  always_comb begin
    ctrl_d   = ctrl_t'(bus_wdata[1:0]);
    reload_d = bus_wdata[CNT_W-1:0];
    tbase_d  = bus_wdata[TB_W-1:0];
    rdata_d  = '0;
    case (bus_addr)
      REG_CTRL:   rdata_d = DW'(ctrl_q);
      REG_RELOAD: rdata_d = DW'(reload_q);
      REG_TBASE:  rdata_d = DW'(tbase_q);
      REG_VALUE:  rdata_d = DW'(cnt_val);
      REG_STAT:   rdata_d = DW'(ovf);
      REG_IRQST:  rdata_d = DW'(pend);
      default:    rdata_d = '0;
    endcase
  end

  // registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      tbase_q  <= '0;
      rdata_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q   <= ctrl_d;
      if (wr_rl)   reload_q <= reload_d;
      if (wr_tb)   tbase_q  <= tbase_d;
      if (bus_rd)  rdata_q  <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign ctrl      = ctrl_q;
  assign reload    = reload_q;
  assign tbase     = tbase_q;
  assign load      = wr_rl;
  assign load_val  = reload_d;
  assign ack       = wr_ctrl && !bus_wdata[CTRL_IRQ_BIT];
  assign stat_rd   = bus_rd && (bus_addr == REG_STAT);

  AST_WIDE_RELOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_RELOAD && bus_wdata[DW-1:CNT_W] != '0) |=> $stable(reload_q)); // R2

  AST_WIDE_TBASE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_TBASE && bus_wdata[DW-1:TB_W] != '0) |=> $stable(tbase_q)); // R2

endmodule

// File: rtl/rld_prescaler.sv
module rld_prescaler #(
  parameter int unsigned TB_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [TB_W-1:0] tbase,
  output logic            tick
);

  logic [TB_W-1:0] psc_q, psc_d;
  logic            psc_en;

  // >= keeps the divider bounded if timebase is lowered mid-count
  assign tick   = run && (psc_q >= tbase);
  assign psc_en = run || restart;

  always_comb begin
    if (restart || tick) begin
      psc_d = '0;
    end else begin
      psc_d = psc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
    end else if (psc_en) begin
      psc_q <= psc_d;
    end
  end

  AST_PSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(psc_q)); // R6

  AST_PSC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (psc_q == '0)); // R2

endmodule

// File: rtl/rld_core.sv
module rld_core #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  input  logic             irq_en,
  input  logic             ack,
  input  logic             stat_rd,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             pend
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             pend_q, pend_d;
  logic             term;
  logic             cnt_en;

  assign term   = tick && (cnt_q == '0) && !load;
  assign cnt_en = tick || load;

  always_comb begin
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q == '0) begin
      cnt_d = reload;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end

    // set wins over read-clear
    if (term) begin
      ovf_d = 1'b1;
    end else if (stat_rd) begin
      ovf_d = 1'b0;
    end else begin
      ovf_d = ovf_q;
    end

    // acknowledge wins over a coincident terminal count
    if (ack) begin
      pend_d = 1'b0;
    end else if (term && irq_en) begin
      pend_d = 1'b1;
    end else begin
      pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      ovf_q  <= ovf_d;
      pend_q <= pend_d;
    end
  end

  assign cnt  = cnt_q;
  assign ovf  = ovf_q;
  assign pend = pend_q;

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt_q == '0) |=> (cnt_q == $past(reload) && ovf_q)); // R4

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q)); // R6

  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(irq_en)); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !pend_q); // R9

endmodule

// File: rtl/rld_timer.sv
module rld_timer
  import rld_timer_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 12,
  parameter int unsigned TB_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);

  logic             rst_s_n;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, load_val, cnt;
  logic [TB_W-1:0]  tbase;
  logic             load, ack, stat_rd, tick, ovf, pend;

  rld_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  rld_regs #(.DW(DW), .CNT_W(CNT_W), .TB_W(TB_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_val   (cnt),
    .ovf       (ovf),
    .pend      (pend),
    .bus_rdata (bus_rdata),
    .ctrl      (ctrl),
    .reload    (reload),
    .tbase     (tbase),
    .load      (load),
    .load_val  (load_val),
    .ack       (ack),
    .stat_rd   (stat_rd)
  );

  rld_prescaler #(.TB_W(TB_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .run     (ctrl.run),
    .restart (load),
    .tbase   (tbase),
    .tick    (tick)
  );

  rld_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .tick     (tick),
    .load     (load),
    .load_val (load_val),
    .reload   (reload),
    .irq_en   (ctrl.irq_en),
    .ack      (ack),
    .stat_rd  (stat_rd),
    .cnt      (cnt),
    .ovf      (ovf),
    .pend     (pend)
  );

  assign irq = pend;

  AST_IRQ_OFF_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_wr && bus_addr == REG_CTRL && !bus_wdata[CTRL_IRQ_BIT]) |=> !irq); // R9

  AST_READ_RANGE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rd && bus_addr == REG_VALUE) |=> (bus_rdata[DW-1:CNT_W] == '0)); // R10

endmodule

// File: tb/rld_timer_tb_top.sv
module rld_timer_tb_top;
  import rld_timer_pkg::*;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [11:0] rl;
    logic [11:0] tb;
    logic [15:0] w;
    logic [11:0] val;
    logic        ovf;
    logic        irq;
  } vec_t;

  // reload, timebase, run cycles, expected count, overflow, irq
  localparam vec_t VECS [0:6] = '{
    '{12'd5,    12'd0, 16'd3,  12'd1,     1'b0, 1'b0},
    '{12'd5,    12'd0, 16'd8,  12'd2,     1'b1, 1'b1},
    '{12'd3,    12'd2, 16'd10, 12'd0,     1'b0, 1'b0},
    '{12'd3,    12'd2, 16'd11, 12'd3,     1'b1, 1'b0},
    '{12'd0,    12'd1, 16'd4,  12'd0,     1'b1, 1'b1},
    '{12'hFFF,  12'd0, 16'd20, 12'hFEA,   1'b0, 1'b0},
    '{12'd10,   12'd4, 16'd0,  12'd10,    1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rld_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R10 unused indices read zero
    check("R1 irq", 32'(irq), 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check(a > 5 ? "R10 unused" : "R1 reg", d, 0);
    end

    // table: R3 decrement, R4 wrap/overflow, R7 irq
    for (int i = 0; i < 7; i++) begin
      wr(REG_TBASE, 32'(VECS[i].tb));
      wr(REG_RELOAD, 32'(VECS[i].rl));
      wr(REG_CTRL, 32'h3);
      repeat (VECS[i].w) @(negedge clk);
      check("R7 irq", 32'(irq), 32'(VECS[i].irq));
      wr(REG_CTRL, 32'h0);
      rd(REG_VALUE, d);
      check("R3 count", d, 32'(VECS[i].val));
      rd(REG_STAT, d);
      check("R4 overflow", d, 32'(VECS[i].ovf));
    end

    // R2 range rejection and load-on-write
    wr(REG_RELOAD, 32'd7);
    wr(REG_RELOAD, 32'h1000);
    rd(REG_RELOAD, d);  check("R2 reload kept", d, 7);
    rd(REG_VALUE, d);   check("R2 counter loaded", d, 7);
    wr(REG_TBASE, 32'd3);
    wr(REG_TBASE, 32'h8000_0001);
    rd(REG_TBASE, d);   check("R2 timebase kept", d, 3);
    wr(REG_CTRL, 32'h2);
    rd(REG_CTRL, d);    check("R10 ctrl readback", d, 2);
    repeat (5) @(negedge clk);
    rd(REG_VALUE, d);   check("R6 hold while stopped", d, 7);
    wr(REG_CTRL, 32'h0);

    // R8 run without interrupt enable
    wr(REG_TBASE, 32'd0);
    wr(REG_RELOAD, 32'd1);
    wr(REG_CTRL, 32'h1);
    repeat (4) @(negedge clk);
    check("R8 irq stays low", 32'(irq), 0);
    wr(REG_CTRL, 32'h0);
    rd(REG_IRQST, d);   check("R8 no pending", d, 0);
    rd(REG_STAT, d);    check("R8 overflow set", d, 1);
    rd(REG_STAT, d);    check("R5 read clears", d, 0);

    // R7/R9 acknowledge by zero then restore
    wr(REG_RELOAD, 32'd2);
    wr(REG_CTRL, 32'h3);
    repeat (3) @(negedge clk);
    check("R7 irq at terminal", 32'(irq), 1);
    rd(REG_IRQST, d);   check("R7 pending bit", d, 1);
    wr(REG_CTRL, 32'h0);
    check("R9 irq cleared", 32'(irq), 0);
    rd(REG_VALUE, d);   check("R9 count held", d, 0);
    repeat (5) @(negedge clk);
    rd(REG_VALUE, d);   check("R6 count frozen", d, 0);
    wr(REG_CTRL, 32'h3);
    rd(REG_VALUE, d);   check("R9 resume from held", d, 0);
    check("R9 irq after resume", 32'(irq), 1);
    rd(REG_VALUE, d);   check("R4 reloaded after resume", d, 2);
    wr(REG_CTRL, 32'h0);
    rd(REG_STAT, d);    check("R4 overflow after resume", d, 1);

    // R5 terminal count coinciding with status read
    wr(REG_TBASE, 32'd1);
    wr(REG_RELOAD, 32'd0);
    wr(REG_CTRL, 32'h1);
    rd(REG_STAT, d);    check("R5 before terminal", d, 0);
    rd(REG_STAT, d);    check("R5 read at terminal", d, 0);
    wr(REG_CTRL, 32'h0);
    rd(REG_STAT, d);    check("R5 set wins over clear", d, 1);
    rd(REG_STAT, d);    check("R5 cleared", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule